// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit integer processor that retires one instruction on every rising clock edge. It has separate instruction-fetch and data-memory ports, a program counter and a 32-entry general register file. The instruction memory and the data memory are read combinationally: the core puts out the fetch address, receives the instruction word in the same cycle, decodes and executes it, and updates the PC, the register file and, for stores, the data memory at the next rising edge.

The supported set is ten instructions: register-to-register add, subtract, bitwise and, bitwise or and signed set-on-less-than; load word; store word; branch on equal; add immediate; and an absolute jump. Decoding is split in two. A main decoder turns the opcode into datapath controls, and a separate ALU decoder chooses the ALU operation from those controls and the function field. Register 0 is hard-wired to zero. An opcode outside the set does nothing and the PC advances by 4.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, the PC (imem_addr_o) is 0 and dmem_we_o is low. The reset takes effect without a clock. It also clears every general register, so after release a register reads 0 until it is written.
- R2: The instruction fields sit at fixed bit positions: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], immediate [15:0] and jump target [25:0]. Exactly one instruction completes per clock cycle. Any instruction that is not a taken branch or a jump sets the next PC to PC+4.
- R3: R-type instructions (opcode 0x00) read rs and rt and write the result to rd. Function code 0x20 adds, 0x22 subtracts rt from rs, 0x24 is bitwise and, and 0x25 is bitwise or.
- R4: R-type function code 0x2A writes 1 to rd when rs is less than rt as two's-complement values, and writes 0 otherwise.
- R5: Load word (opcode 0x23) drives dmem_addr_o with rs plus the sign-extended immediate, keeps dmem_we_o low, and writes dmem_rdata_i into rt.
- R6: Store word (opcode 0x2B) asserts dmem_we_o for that cycle. It drives dmem_addr_o with rs plus the sign-extended immediate and dmem_wdata_o with the value of rt. No other instruction asserts dmem_we_o.
- R7: Add immediate (opcode 0x08) writes rs plus the sign-extended 16-bit immediate into rt.
- R8: Branch on equal (opcode 0x04) sets the next PC to PC+4 plus the sign-extended immediate shifted left by 2 when rs equals rt, and to PC+4 otherwise. Backward offsets are included.
- R9: Jump (opcode 0x02) sets the next PC to the top 4 bits of PC+4, followed by the 26-bit target, followed by two zero bits.
- R10: Register 0 always reads as zero. Writes that name it as destination have no effect.
- R11: An opcode outside the supported set writes no register and no memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 32 | Current PC, used as the instruction fetch byte address |
| imem_data_i | input | 32 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata_o | output | 32 | Store data, taken from register rt |
| dmem_we_o | output | 1 | Data memory write enable, high for a store |
| dmem_rdata_i | input | 32 | Data memory read word at dmem_addr_o |

## Verification
The bench runs a program through a table. At every step it checks the PC and the data-port activity, and register contents come out through stores. Signed set-on-less-than is tested with a negative operand in both operand positions; a core that compared unsigned would return 0 and 1 reversed. Sign extension is tested with negative immediates in an add-immediate and in a backward branch; a core that zero-extended would compute a wrong value or jump forward. The bench also covers these faults: a not-taken branch that still jumps, a write to register 0 that can later be read back nonzero, an unknown opcode that behaves like an add-immediate and corrupts a register, and a store issued while reset is held or reading a register that reset did not clear.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned FUNC_W  = 6;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned TGT_W   = 26;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JMP   = 6'h02;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

  localparam logic [FUNC_W-1:0] FN_ADD = 6'h20;
  localparam logic [FUNC_W-1:0] FN_SUB = 6'h22;
  localparam logic [FUNC_W-1:0] FN_AND = 6'h24;
  localparam logic [FUNC_W-1:0] FN_OR  = 6'h25;
  localparam logic [FUNC_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'd0,
    CLS_SUB   = 2'd1,
    CLS_FUNCT = 2'd2
  } alu_cls_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'd0,
    ALU_OR  = 3'd1,
    ALU_ADD = 3'd2,
    ALU_SUB = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic     reg_we;
    logic     dst_rd;
    logic     src_imm;
    logic     mem_to_reg;
    logic     mem_we;
    logic     branch;
    logic     jump;
    alu_cls_e alu_cls;
  } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_core_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output ctrl_t            ctrl_o
);

  always_comb begin
    ctrl_o = '{reg_we: 1'b0, dst_rd: 1'b0, src_imm: 1'b0, mem_to_reg: 1'b0,
               mem_we: 1'b0, branch: 1'b0, jump: 1'b0, alu_cls: CLS_ADD};
    unique case (opcode_i)
      OPC_RTYPE: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.dst_rd  = 1'b1;
        ctrl_o.alu_cls = CLS_FUNCT;
      end
      OPC_LOAD: begin
        ctrl_o.reg_we     = 1'b1;
        ctrl_o.src_imm    = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
      end
      OPC_STORE: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.branch  = 1'b1;
        ctrl_o.alu_cls = CLS_SUB;
      end
      OPC_ADDI: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.src_imm = 1'b1;
      end
      OPC_JMP:  ctrl_o.jump = 1'b1;
      default:  ;
    endcase
  end

endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_core_pkg::*;
(
  input  alu_cls_e          cls_i,
  input  logic [FUNC_W-1:0] funct_i,
  output alu_op_e           op_o,
  output logic              ok_o
);

  always_comb begin
    op_o = ALU_ADD;
    ok_o = 1'b1;
    unique case (cls_i)
      CLS_ADD: op_o = ALU_ADD;
      CLS_SUB: op_o = ALU_SUB;
      CLS_FUNCT: begin
        unique case (funct_i)
          FN_ADD:  op_o = ALU_ADD;
          FN_SUB:  op_o = ALU_SUB;
          FN_AND:  op_o = ALU_AND;
          FN_OR:   op_o = ALU_OR;
          FN_SLT:  op_o = ALU_SLT;
          default: ok_o = 1'b0;
        endcase
      end
      default: ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_op_e          op_i,
  output logic [WIDTH-1:0] y_o,
  output logic             zero_o
);

  logic [WIDTH-1:0] diff;
  assign diff = a_i - b_i;

  always_comb begin
    unique case (op_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = diff;
      ALU_SLT: y_o = {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = '0;
    endcase
  end

  assign zero_o = (diff == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] raddr_a_i,
  input  logic [IDX_W-1:0] raddr_b_i,
  output logic [WIDTH-1:0] rdata_a_o,
  output logic [WIDTH-1:0] rdata_b_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [WIDTH-1:0] wdata_i
);

  logic [WIDTH-1:0] rd_arr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign rd_arr[i] = '0;
    end else begin : g_flop
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                q <= '0;
        else if (we_i && (waddr_i == IDX_W'(i)))    q <= wdata_i;
      end
      assign rd_arr[i] = q;
    end
  end

  assign rdata_a_o = rd_arr[raddr_a_i];
  assign rdata_b_o = rd_arr[raddr_b_i];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned REG_NUM = 32,
  localparam int unsigned RIDX_W = $clog2(REG_NUM)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [31:0]     imem_data_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  output logic            dmem_we_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);

  // instruction fields
  logic [OPC_W-1:0]  opcode;
  logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx;
  logic [FUNC_W-1:0] funct;
  logic [IMM_W-1:0]  imm;
  logic [TGT_W-1:0]  target;
  logic              unused_shamt;

  assign opcode       = imem_data_i[31:26];
  assign rs_idx       = imem_data_i[21 +: RIDX_W];
  assign rt_idx       = imem_data_i[16 +: RIDX_W];
  assign rd_idx       = imem_data_i[11 +: RIDX_W];
  assign funct        = imem_data_i[FUNC_W-1:0];
  assign imm          = imem_data_i[IMM_W-1:0];
  assign target       = imem_data_i[TGT_W-1:0];
  assign unused_shamt = ^imem_data_i[10:6];

  ctrl_t   ctrl;
  alu_op_e alu_op;
  logic    fn_ok;

  sc_main_dec u_main_dec (
    .opcode_i (opcode),
    .ctrl_o   (ctrl)
  );

  sc_alu_dec u_alu_dec (
    .cls_i   (ctrl.alu_cls),
    .funct_i (funct),
    .op_o    (alu_op),
    .ok_o    (fn_ok)
  );

  // register file
  logic [XLEN-1:0]   rs_data, rt_data, wb_data;
  logic [RIDX_W-1:0] wb_idx;
  logic              wb_en;

  assign wb_idx = ctrl.dst_rd ? rd_idx : rt_idx;
  assign wb_en  = ctrl.reg_we & fn_ok;

  sc_regfile #(
    .WIDTH (XLEN),
    .DEPTH (REG_NUM)
  ) u_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raddr_a_i (rs_idx),
    .raddr_b_i (rt_idx),
    .rdata_a_o (rs_data),
    .rdata_b_o (rt_data),
    .we_i      (wb_en),
    .waddr_i   (wb_idx),
    .wdata_i   (wb_data)
  );

  // execute
  logic [XLEN-1:0] simm, alu_b, alu_y;
  logic            alu_zero;

  assign simm  = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign alu_b = ctrl.src_imm ? simm : rt_data;

  sc_alu #(.WIDTH(XLEN)) u_alu (
    .a_i    (rs_data),
    .b_i    (alu_b),
    .op_i   (alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  assign wb_data = ctrl.mem_to_reg ? dmem_rdata_i : alu_y;

  // next pc
  logic [XLEN-1:0] pc_q, pc_plus4, pc_branch, pc_jump, pc_next;

  assign pc_plus4  = pc_q + XLEN'(4);
  assign pc_branch = pc_plus4 + {simm[XLEN-3:0], 2'b00};
  assign pc_jump   = {pc_plus4[XLEN-1:TGT_W+2], target, 2'b00};

  always_comb begin
    pc_next = pc_plus4;
    if (ctrl.jump)                   pc_next = pc_jump;
    else if (ctrl.branch && alu_zero) pc_next = pc_branch;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_data;
  assign dmem_we_o    = ctrl.mem_we & rst_ni;  // no store while held in reset

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc,
  input logic [31:0]     instr,
  input logic            dmem_we,
  input logic [XLEN-1:0] rs_data,
  input logic [XLEN-1:0] rt_data
);

  logic [5:0]      opc;
  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc;
  logic            is_beq, is_jmp;

  assign opc    = instr[31:26];
  assign is_beq = (opc == 6'h04);
  assign is_jmp = (opc == 6'h02);
  assign seq_pc = pc + XLEN'(4);
  assign br_pc  = seq_pc + XLEN'({{(XLEN-18){instr[15]}}, instr[15:0], 2'b00});
  assign jmp_pc = {seq_pc[XLEN-1:28], instr[25:0], 2'b00};

  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (pc == '0) && !dmem_we);

  p_pc_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_beq && !is_jmp) |=> (pc == $past(seq_pc)));

  p_pc_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc[1:0] == 2'b00);

  p_store_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we |-> (opc == 6'h2B));

  p_beq_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_beq && (rs_data == rt_data)) |=> (pc == $past(br_pc)));

  p_beq_not_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_beq && (rs_data != rt_data)) |=> (pc == $past(seq_pc)));

  p_jump_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_jmp |=> (pc == $past(jmp_pc)));

  p_zero_reg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr[25:21] == 5'd0) |-> (rs_data == '0));

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pc      (imem_addr_o),
  .instr   (imem_data_i),
  .dmem_we (dmem_we_o),
  .rs_data (rs_data),
  .rt_data (rt_data)
);

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;

  localparam int unsigned NSTEP  = 30;
  localparam logic [31:0] FILLER = 32'hAC010040;  // store r1 to 0x40; must never run

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] ins;
    logic        we;
    logic        ma;
    logic [31:0] addr;
    logic [31:0] data;
    logic [7:0]  req;
  } step_t;

  // pc, instruction, expected we, address checked, expected addr, expected wdata, requirement
  localparam step_t TRACE [NSTEP] = '{
    '{32'h00, 32'h20010005, 1'b0, 1'b0, 32'h00, 32'h0,        8'd7},  // R7 r1=5
    '{32'h04, 32'h2002FFFD, 1'b0, 1'b0, 32'h00, 32'h0,        8'd7},  // R7 r2=-3
    '{32'h08, 32'h00221820, 1'b0, 1'b0, 32'h00, 32'h0,        8'd3},  // R3 add r3
    '{32'h0C, 32'hAC030000, 1'b1, 1'b1, 32'h00, 32'h2,        8'd3},  // R3 sw r3
    '{32'h10, 32'h00222022, 1'b0, 1'b0, 32'h00, 32'h0,        8'd3},  // R3 sub r4
    '{32'h14, 32'hAC040004, 1'b1, 1'b1, 32'h04, 32'h8,        8'd3},
    '{32'h18, 32'h0041282A, 1'b0, 1'b0, 32'h00, 32'h0,        8'd4},  // R4 slt -3<5
    '{32'h1C, 32'hAC050008, 1'b1, 1'b1, 32'h08, 32'h1,        8'd4},
    '{32'h20, 32'h0022302A, 1'b0, 1'b0, 32'h00, 32'h0,        8'd4},  // R4 slt 5<-3
    '{32'h24, 32'hAC06000C, 1'b1, 1'b1, 32'h0C, 32'h0,        8'd4},
    '{32'h28, 32'h20080FF0, 1'b0, 1'b0, 32'h00, 32'h0,        8'd7},
    '{32'h2C, 32'h20093C3C, 1'b0, 1'b0, 32'h00, 32'h0,        8'd7},
    '{32'h30, 32'h01095024, 1'b0, 1'b0, 32'h00, 32'h0,        8'd3},  // R3 and
    '{32'h34, 32'h01095825, 1'b0, 1'b0, 32'h00, 32'h0,        8'd3},  // R3 or
    '{32'h38, 32'hAC0A0010, 1'b1, 1'b1, 32'h10, 32'h0C30,     8'd3},
    '{32'h3C, 32'hAC0B0014, 1'b1, 1'b1, 32'h14, 32'h3FFC,     8'd3},
    '{32'h40, 32'h8C0C0004, 1'b0, 1'b1, 32'h04, 32'h0,        8'd5},  // R5 lw r12
    '{32'h44, 32'h20000007, 1'b0, 1'b0, 32'h00, 32'h0,        8'd10}, // R10 write r0
    '{32'h48, 32'hAC000018, 1'b1, 1'b1, 32'h18, 32'h0,        8'd10},
    '{32'h4C, 32'hAC0C001C, 1'b1, 1'b1, 32'h1C, 32'h8,        8'd5},
    '{32'h50, 32'h1022000A, 1'b0, 1'b0, 32'h00, 32'h0,        8'd8},  // R8 not taken
    '{32'h54, 32'h10210002, 1'b0, 1'b0, 32'h00, 32'h0,        8'd8},  // R8 taken fwd
    '{32'h60, 32'h0800001E, 1'b0, 1'b0, 32'h00, 32'h0,        8'd9},  // R9 jump
    '{32'h78, 32'h1000FFFA, 1'b0, 1'b0, 32'h00, 32'h0,        8'd8},  // R8 taken back
    '{32'h64, 32'hAC010020, 1'b1, 1'b1, 32'h20, 32'h5,        8'd6},  // R6
    '{32'h68, 32'hFC3FFFFF, 1'b0, 1'b0, 32'h00, 32'h0,        8'd11}, // R11 bad opcode
    '{32'h6C, 32'hAC1F0024, 1'b1, 1'b1, 32'h24, 32'h0,        8'd11},
    '{32'h70, 32'h08000020, 1'b0, 1'b0, 32'h00, 32'h0,        8'd9},
    '{32'h80, 32'h08000020, 1'b0, 1'b0, 32'h00, 32'h0,        8'd9},
    '{32'h80, 32'h08000020, 1'b0, 1'b0, 32'h00, 32'h0,        8'd2}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] imem_addr_o, imem_data_i;
  logic [31:0] dmem_addr_o, dmem_wdata_o, dmem_rdata_i;
  logic        dmem_we_o;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk_i = ~clk_i;

  assign imem_data_i  = imem[imem_addr_o[7:2]];
  assign dmem_rdata_i = dmem[dmem_addr_o[7:2]];

  always @(posedge clk_i) if (dmem_we_o) dmem[dmem_addr_o[7:2]] <= dmem_wdata_o;

  sc_core u_sc_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .imem_addr_o  (imem_addr_o),
    .imem_data_i  (imem_data_i),
    .dmem_addr_o  (dmem_addr_o),
    .dmem_wdata_o (dmem_wdata_o),
    .dmem_we_o    (dmem_we_o),
    .dmem_rdata_i (dmem_rdata_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = FILLER;
      dmem[i] = '0;
    end
    for (int i = 0; i < NSTEP; i++) imem[TRACE[i].pc[7:2]] = TRACE[i].ins;

    // R1: reset state
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 pc in reset", imem_addr_o, 32'h0);
    chk("R1 we in reset", {31'b0, dmem_we_o}, 32'h0);
    rst_ni = 1'b1;

    // R2: trace walk, one instruction per cycle
    for (int s = 0; s < NSTEP; s++) begin
      chk($sformatf("R2 pc step %0d (R%0d)", s, TRACE[s].req), imem_addr_o, TRACE[s].pc);
      chk($sformatf("R%0d we step %0d", TRACE[s].req, s), {31'b0, dmem_we_o}, {31'b0, TRACE[s].we});
      if (TRACE[s].ma)
        chk($sformatf("R%0d addr step %0d", TRACE[s].req, s), dmem_addr_o, TRACE[s].addr);
      if (TRACE[s].we)
        chk($sformatf("R%0d wdata step %0d", TRACE[s].req, s), dmem_wdata_o, TRACE[s].data);
      @(posedge clk_i);
      @(negedge clk_i);
    end

    // R5: loaded word landed in memory image via later store
    chk("R5 dmem[7] after load/store", dmem[7], 32'h8);
    chk("R10 dmem[6] from r0", dmem[6], 32'h0);
    chk("R11 no stray filler store", dmem[16], 32'h0);

    // R1: asynchronous reset mid-cycle, store at pc 0 must be held off
    imem[0] = 32'hAC010000;  // store r1 to address 0
    #2 rst_ni = 1'b0;
    #1;
    chk("R1 async pc clear", imem_addr_o, 32'h0);
    chk("R1 store gated in reset", {31'b0, dmem_we_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 store after release", {31'b0, dmem_we_o}, 32'h1);
    chk("R1 r1 cleared by reset", dmem_wdata_o, 32'h0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R2 pc after restart", imem_addr_o, 32'h4);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule